// File: doc/BRIEF.md
# DDR3 device command decoder

This block is the command front end of a DDR3-style SDRAM device model. On every rising clock edge it captures chip select, the three active-low command strobes, clock enable, the bank and address buses and the termination request pin. From these it works out which command the controller issued. It also keeps, for each bank, a record of whether a row is open, and it tracks whether the device is running, in one of the two power-down modes, or in self-refresh.

The results are all registered and appear one clock after the sampling edge: a command code, the target bank, the row or column or mode op-code taken from the address bus, and the per-command meanings of address bits 10 and 12 (auto-precharge, all-bank precharge, burst chop). It also gives an effective termination enable, which combines the pin with the mode-register setting and with the power state, and a sticky protocol-error flag. The storage array, data timing and analog parts are not modelled.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: When csN is sampled high the command is masked, and cmdOut reports NOP (0) whatever rasN, casN and weN are.
- R2: With csN low and the block running, {rasN,casN,weN} decodes as 011 Activate (cmdOut 1), 101 Read (2), 100 Write (3), 010 Precharge (4), 000 Mode Register Set (5), 001 Refresh (6). Every other pattern reports NOP (0). Code 7 reports self-refresh entry.
- R3: Activate puts the bank on bankOut and the full address on rowOut, with colOut at 0, and marks that bank's row as open.
- R4: A Read or Write puts addr[9:0] on colOut and the bank on bankOut. It drives apOut from addr[10]. When addr[10] is high, the bank's row is closed after the access.
- R5: A Read or Write drives bcOut high exactly when addr[12] is low.
- R6: A Precharge with addr[10] high sets allBankOut, reports bankOut 0 and closes every bank. With addr[10] low it closes only the bank on ba and reports it on bankOut.
- R7: A Mode Register Set puts the address on opOut and the register index on bankOut. A write to index 1 turns termination on when any of addr bits 2, 6 or 9 is set, and off otherwise. Termination is off after reset.
- R8: A Read or Write to a bank with no open row is reported as NOP and sets protoErr. protoErr stays set until reset.
- R9: Taking cke low while running enters precharge power-down (pwrState 1) if all banks are idle, and active power-down (2) if any row is open. cke high returns to running (0). No command is decoded while powered down or on the exit cycle.
- R10: A Refresh sampled with cke low and all banks idle enters self-refresh (pwrState 3) and reports cmdOut 7. With a row open it enters active power-down instead. Self-refresh decodes nothing and exits when cke is sampled high.
- R11: odtEff is high only when odt is high, termination is on, and the next power state is not self-refresh.
- R12: Reset gives cmdOut 0, pwrState 0, all banks idle, termination off, protoErr 0 and all data outputs 0. Every output changes only at the rising edge that samples its inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock, rising edge samples |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable strobe, active low |
| odt | input | 1 | Termination request pin |
| ba | input | BA_W | Bank address / mode register index |
| addr | input | ADDR_W | Address / op-code bus |
| cmdOut | output | 3 | Decoded command code |
| bankOut | output | BA_W | Target bank or register index |
| rowOut | output | ADDR_W | Row of an Activate |
| colOut | output | COL_W | Column of a Read or Write |
| opOut | output | ADDR_W | Op-code of a Mode Register Set |
| apOut | output | 1 | Auto-precharge requested |
| bcOut | output | 1 | Burst chop requested |
| allBankOut | output | 1 | Precharge applies to all banks |
| odtEff | output | 1 | Effective termination enable |
| pwrState | output | 2 | 0 run, 1 precharge PD, 2 active PD, 3 self-refresh |
| protoErr | output | 1 | Sticky access-to-closed-bank error |

## Verification
Each output is registered once, so it is due at the first rising edge after its inputs are driven. The same holds for power-state changes and error flags. The bench drives inputs at the falling edge and samples 1 ns after the next rising edge. One directed check also confirms that nothing moves before that edge. Open-row state is never read directly: it shows up one command later, through whether a Read is accepted, whether a Refresh with cke low enters self-refresh, and which power-down mode is chosen.

// File: rtl/ddr_cmd_pkg.sv
`timescale 1ns/1ps
package ddr_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_MRS = 3'd5,
    CMD_REF = 3'd6,
    CMD_SRE = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ON    = 2'd0,
    PWR_PREPD = 2'd1,
    PWR_ACTPD = 2'd2,
    PWR_SELF  = 2'd3
  } pwr_e;

  // strobes from control to datapath
  typedef struct packed {
    cmd_e cmd;
    logic takeBank;
    logic takeRow;
    logic takeCol;
    logic takeOp;
    logic autoPre;
    logic chop;
    logic allBank;
    logic mr1Load;
    logic odtGate;
  } strobe_t;

endpackage

// File: rtl/ddr_cmd_ctrl.sv
`timescale 1ns/1ps
module ddr_cmd_ctrl
  import ddr_cmd_pkg::*;
#(
  parameter int BANKS   = 8,
  parameter int BA_W    = 3,
  parameter int ADDR_W  = 15,
  parameter int AP_BIT  = 10,
  parameter int BC_BIT  = 12,
  parameter int MR1_IDX = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output pwr_e              pwrState,
  output logic              protoErr
);

  localparam logic [BA_W-1:0] MR1_SEL = BA_W'(MR1_IDX);

  cmd_e             rawCmd;
  pwr_e             pwrNext;
  logic [BANKS-1:0] bankOpen;
  logic [BANKS-1:0] openNext;
  logic [BANKS-1:0] bankHit;
  logic             allIdle;
  logic             hitOpen;
  logic             errSet;

  // one-hot select of the addressed bank
  for (genvar b = 0; b < BANKS; b++) begin : g_hit
    assign bankHit[b] = (ba == BA_W'(b));
  end

  assign allIdle = ~|bankOpen;
  assign hitOpen = |(bankOpen & bankHit);

  always_comb begin
    rawCmd = CMD_NOP;
    if (!csN) begin
      case ({rasN, casN, weN})
        3'b011:  rawCmd = CMD_ACT;
        3'b101:  rawCmd = CMD_RD;
        3'b100:  rawCmd = CMD_WR;
        3'b010:  rawCmd = CMD_PRE;
        3'b000:  rawCmd = CMD_MRS;
        3'b001:  rawCmd = CMD_REF;
        default: rawCmd = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    stb      = '0;
    stb.cmd  = CMD_NOP;
    pwrNext  = pwrState;
    openNext = bankOpen;
    errSet   = 1'b0;
    if (pwrState != PWR_ON) begin
      if (cke) pwrNext = PWR_ON;
    end else if (!cke) begin
      if (rawCmd == CMD_REF && allIdle) begin
        pwrNext = PWR_SELF;
        stb.cmd = CMD_SRE;
      end else if (allIdle) begin
        pwrNext = PWR_PREPD;
      end else begin
        pwrNext = PWR_ACTPD;
      end
    end else begin
      case (rawCmd)
        CMD_ACT: begin
          stb.cmd      = CMD_ACT;
          stb.takeBank = 1'b1;
          stb.takeRow  = 1'b1;
          openNext     = bankOpen | bankHit;
        end
        CMD_RD, CMD_WR: begin
          if (hitOpen) begin
            stb.cmd      = rawCmd;
            stb.takeBank = 1'b1;
            stb.takeCol  = 1'b1;
            stb.autoPre  = addr[AP_BIT];
            stb.chop     = ~addr[BC_BIT];
            if (addr[AP_BIT]) openNext = bankOpen & ~bankHit;
          end else begin
            errSet = 1'b1;
          end
        end
        CMD_PRE: begin
          stb.cmd = CMD_PRE;
          if (addr[AP_BIT]) begin
            stb.allBank = 1'b1;
            openNext    = '0;
          end else begin
            stb.takeBank = 1'b1;
            openNext     = bankOpen & ~bankHit;
          end
        end
        CMD_MRS: begin
          stb.cmd      = CMD_MRS;
          stb.takeBank = 1'b1;
          stb.takeOp   = 1'b1;
          stb.mr1Load  = (ba == MR1_SEL);
        end
        CMD_REF: stb.cmd = CMD_REF;
        default: stb.cmd = CMD_NOP;
      endcase
    end
    stb.odtGate = (pwrNext != PWR_SELF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrState <= PWR_ON;
      bankOpen <= '0;
      protoErr <= 1'b0;
    end else begin
      pwrState <= pwrNext;
      bankOpen <= openNext;
      protoErr <= protoErr | errSet;
    end
  end

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R6
  all_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.allBank |=> (bankOpen == '0));

  // R10
  self_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_SELF) |-> (bankOpen == '0));

  // R9
  act_pd_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_ACTPD) |-> (bankOpen != '0));

endmodule

// File: rtl/ddr_cmd_dpath.sv
`timescale 1ns/1ps
module ddr_cmd_dpath
  import ddr_cmd_pkg::*;
#(
  parameter int BA_W    = 3,
  parameter int ADDR_W  = 15,
  parameter int COL_W   = 10,
  parameter int TERM_B0 = 2,
  parameter int TERM_B1 = 6,
  parameter int TERM_B2 = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              odt,
  output cmd_e              cmdOut,
  output logic [BA_W-1:0]   bankOut,
  output logic [ADDR_W-1:0] rowOut,
  output logic [COL_W-1:0]  colOut,
  output logic [ADDR_W-1:0] opOut,
  output logic              apOut,
  output logic              bcOut,
  output logic              allBankOut,
  output logic              odtEff
);

  localparam logic [ADDR_W-1:0] TERM_MASK =
    (ADDR_W'(1) << TERM_B0) | (ADDR_W'(1) << TERM_B1) | (ADDR_W'(1) << TERM_B2);

  logic termOn;
  logic termNext;

  assign termNext = stb.mr1Load ? |(addr & TERM_MASK) : termOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdOut     <= CMD_NOP;
      bankOut    <= '0;
      rowOut     <= '0;
      colOut     <= '0;
      opOut      <= '0;
      apOut      <= 1'b0;
      bcOut      <= 1'b0;
      allBankOut <= 1'b0;
      termOn     <= 1'b0;
      odtEff     <= 1'b0;
    end else begin
      cmdOut     <= stb.cmd;
      bankOut    <= stb.takeBank ? ba : '0;
      rowOut     <= stb.takeRow ? addr : '0;
      colOut     <= stb.takeCol ? addr[COL_W-1:0] : '0;
      opOut      <= stb.takeOp ? addr : '0;
      apOut      <= stb.autoPre;
      bcOut      <= stb.chop;
      allBankOut <= stb.allBank;
      termOn     <= termNext;
      odtEff     <= odt & termNext & stb.odtGate;
    end
  end

endmodule

// File: rtl/ddr_cmd_decoder.sv
`timescale 1ns/1ps
module ddr_cmd_decoder
  import ddr_cmd_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int ADDR_W = 15,
  parameter int COL_W  = 10,
  localparam int BA_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              odt,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        cmdOut,
  output logic [BA_W-1:0]   bankOut,
  output logic [ADDR_W-1:0] rowOut,
  output logic [COL_W-1:0]  colOut,
  output logic [ADDR_W-1:0] opOut,
  output logic              apOut,
  output logic              bcOut,
  output logic              allBankOut,
  output logic              odtEff,
  output logic [1:0]        pwrState,
  output logic              protoErr
);

  strobe_t stb;
  pwr_e    pwrQ;
  cmd_e    cmdQ;

  ddr_cmd_ctrl #(
    .BANKS (BANKS),
    .BA_W  (BA_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cke     (cke),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .ba      (ba),
    .addr    (addr),
    .stb     (stb),
    .pwrState(pwrQ),
    .protoErr(protoErr)
  );

  ddr_cmd_dpath #(
    .BA_W  (BA_W),
    .ADDR_W(ADDR_W),
    .COL_W (COL_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ba        (ba),
    .addr      (addr),
    .odt       (odt),
    .cmdOut    (cmdQ),
    .bankOut   (bankOut),
    .rowOut    (rowOut),
    .colOut    (colOut),
    .opOut     (opOut),
    .apOut     (apOut),
    .bcOut     (bcOut),
    .allBankOut(allBankOut),
    .odtEff    (odtEff)
  );

  assign cmdOut   = cmdQ;
  assign pwrState = pwrQ;

  // R1
  cs_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (cmdQ == CMD_NOP));

  // R11
  self_odt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ == PWR_SELF) |-> !odtEff);

  // R10
  self_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ == PWR_SELF) |-> (cmdQ == CMD_NOP || cmdQ == CMD_SRE));

endmodule

// File: tb/ddr_cmd_decoder_test.sv
`timescale 1ns/1ps
module ddr_cmd_decoder_test;

  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, odt = 1'b0;
  logic [2:0]  ba = '0;
  logic [14:0] addr = '0;
  logic [2:0]  cmdOut, bankOut;
  logic [14:0] rowOut, opOut;
  logic [9:0]  colOut;
  logic        apOut, bcOut, allBankOut, odtEff, protoErr;
  logic [1:0]  pwrState;
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  ddr_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .odt(odt), .ba(ba), .addr(addr), .cmdOut(cmdOut),
    .bankOut(bankOut), .rowOut(rowOut), .colOut(colOut), .opOut(opOut),
    .apOut(apOut), .bcOut(bcOut), .allBankOut(allBankOut), .odtEff(odtEff),
    .pwrState(pwrState), .protoErr(protoErr)
  );

  // {csN,rasN,casN,weN}, cke, odt, ba, addr | cmd, bank, {ap,bc,all}, pwr, odtEff, err
  localparam logic [36:0] VEC [NV] = '{
    {4'b0000,1'b1,1'b1,3'd1,15'h0004, 3'd5,3'd1,3'b000,2'd0,1'b1,1'b0}, // MR1 term on
    {4'b0011,1'b1,1'b0,3'd2,15'h1234, 3'd1,3'd2,3'b000,2'd0,1'b0,1'b0}, // ACT b2
    {4'b0101,1'b1,1'b0,3'd2,15'h1005, 3'd2,3'd2,3'b000,2'd0,1'b0,1'b0}, // RD full burst
    {4'b0100,1'b1,1'b0,3'd2,15'h0405, 3'd3,3'd2,3'b110,2'd0,1'b0,1'b0}, // WR ap + chop
    {4'b1011,1'b1,1'b1,3'd3,15'h0000, 3'd0,3'd0,3'b000,2'd0,1'b1,1'b0}, // cs masked
    {4'b0101,1'b1,1'b0,3'd2,15'h1000, 3'd0,3'd0,3'b000,2'd0,1'b0,1'b1}, // RD closed
    {4'b0011,1'b1,1'b0,3'd5,15'h0010, 3'd1,3'd5,3'b000,2'd0,1'b0,1'b1}, // ACT b5
    {4'b0011,1'b1,1'b0,3'd6,15'h0020, 3'd1,3'd6,3'b000,2'd0,1'b0,1'b1}, // ACT b6
    {4'b0010,1'b1,1'b0,3'd5,15'h0000, 3'd4,3'd5,3'b000,2'd0,1'b0,1'b1}, // PRE b5
    {4'b0111,1'b0,1'b0,3'd0,15'h0000, 3'd0,3'd0,3'b000,2'd2,1'b0,1'b1}, // act PD
    {4'b0111,1'b0,1'b0,3'd0,15'h0000, 3'd0,3'd0,3'b000,2'd2,1'b0,1'b1},
    {4'b0111,1'b1,1'b0,3'd0,15'h0000, 3'd0,3'd0,3'b000,2'd0,1'b0,1'b1}, // exit
    {4'b0010,1'b1,1'b0,3'd3,15'h0400, 3'd4,3'd0,3'b001,2'd0,1'b0,1'b1}, // PRE all
    {4'b0001,1'b0,1'b1,3'd0,15'h0000, 3'd7,3'd0,3'b000,2'd3,1'b0,1'b1}, // SR entry
    {4'b0011,1'b0,1'b1,3'd2,15'h0001, 3'd0,3'd0,3'b000,2'd3,1'b0,1'b1}, // in SR
    {4'b0111,1'b1,1'b1,3'd0,15'h0000, 3'd0,3'd0,3'b000,2'd0,1'b1,1'b1}, // SR exit
    {4'b0001,1'b1,1'b0,3'd0,15'h0000, 3'd6,3'd0,3'b000,2'd0,1'b0,1'b1}, // REF
    {4'b0111,1'b0,1'b0,3'd0,15'h0000, 3'd0,3'd0,3'b000,2'd1,1'b0,1'b1}, // pre PD
    {4'b0111,1'b1,1'b0,3'd0,15'h0000, 3'd0,3'd0,3'b000,2'd0,1'b0,1'b1},
    {4'b0000,1'b1,1'b1,3'd1,15'h0000, 3'd5,3'd1,3'b000,2'd0,1'b0,1'b1}, // MR1 term off
    {4'b0111,1'b1,1'b1,3'd0,15'h0000, 3'd0,3'd0,3'b000,2'd0,1'b0,1'b1},
    {4'b0110,1'b1,1'b0,3'd0,15'h0000, 3'd0,3'd0,3'b000,2'd0,1'b0,1'b1}  // undefined code
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic k, input logic o,
                       input logic [2:0] b, input logic [14:0] a);
    @(negedge clk);
    {csN, rasN, casN, weN} = c;
    cke = k; odt = o; ba = b; addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12", "cmd", 32'(cmdOut), 0);
    chk("R12", "pwr", 32'(pwrState), 0);
    chk("R12", "err", 32'(protoErr), 0);
    chk("R12", "odt", 32'(odtEff), 0);
    chk("R12", "row", 32'(rowOut), 0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      drive(v[36:33], v[32], v[31], v[30:28], v[27:13]);
      chk("R2/R1", $sformatf("cmd v%0d", i), 32'(cmdOut), 32'(v[12:10]));
      chk("R3", $sformatf("bank v%0d", i), 32'(bankOut), 32'(v[9:7]));
      chk("R4", $sformatf("ap v%0d", i), 32'(apOut), 32'(v[6]));
      chk("R5", $sformatf("bc v%0d", i), 32'(bcOut), 32'(v[5]));
      chk("R6", $sformatf("all v%0d", i), 32'(allBankOut), 32'(v[4]));
      chk("R9/R10", $sformatf("pwr v%0d", i), 32'(pwrState), 32'(v[3:2]));
      chk("R11/R7", $sformatf("odt v%0d", i), 32'(odtEff), 32'(v[1]));
      chk("R8", $sformatf("err v%0d", i), 32'(protoErr), 32'(v[0]));
    end

    // R12 reset clears the sticky error
    @(negedge clk); rstN = 1'b0;
    #1;
    chk("R12", "err after reset", 32'(protoErr), 0);
    @(negedge clk); rstN = 1'b1;

    // R7 op-code and register index on a non-MR1 write
    drive(4'b0000, 1'b1, 1'b1, 3'd0, 15'h1ABC);
    chk("R7", "op", 32'(opOut), 32'h1ABC);
    chk("R7", "bank", 32'(bankOut), 0);
    chk("R7", "odt stays off", 32'(odtEff), 0);

    // R3 row capture
    drive(4'b0011, 1'b1, 1'b0, 3'd1, 15'h7ABC);
    chk("R3", "row", 32'(rowOut), 32'h7ABC);
    chk("R3", "col", 32'(colOut), 0);
    chk("R3", "op", 32'(opOut), 0);

    // R4 column capture, R5 no chop with A12 high
    drive(4'b0101, 1'b1, 1'b0, 3'd1, 15'h13FF);
    chk("R4", "col", 32'(colOut), 32'h3FF);
    chk("R4", "row", 32'(rowOut), 0);
    chk("R5", "bc", 32'(bcOut), 0);

    // R12 output changes only at the sampling edge
    @(negedge clk);
    {csN, rasN, casN, weN} = 4'b0100; cke = 1'b1; ba = 3'd1; addr = 15'h0000;
    #1;
    chk("R12", "cmd before edge", 32'(cmdOut), 2);
    @(posedge clk); #1;
    chk("R12", "cmd after edge", 32'(cmdOut), 3);

    // R10 refresh with cke low and a row open goes to active power-down
    drive(4'b0001, 1'b0, 1'b0, 3'd0, 15'h0000);
    chk("R10", "no SR with open row", 32'(pwrState), 2);
    chk("R10", "cmd", 32'(cmdOut), 0);
    drive(4'b0111, 1'b1, 1'b0, 3'd0, 15'h0000);
    chk("R9", "exit", 32'(pwrState), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule